// File: doc/BRIEF.md
# Serial Management Slave

This block lets a host reach an on-chip register space through a two-wire serial management link: a host-driven serial clock and one shared bidirectional data line. The host sends frames that open with a run of ones, then a start pattern, an opcode, a two-bit device number, an eight-bit register number, two turnaround bits and a sixteen-bit data field. The slave decodes these frames and turns each valid one into a single access on a simple parallel register bus that runs on the system clock.

Several slaves can share one link. Each compares the device number in the frame with its own two strap inputs and answers only when they match. On a read, the slave takes the line in the second turnaround bit, drives a zero there, and then shifts out the register byte. The upper byte of the data field is always zero. On a write, only the low byte of the data field reaches the register bus. The serial clock and data line are synchronised into the system clock domain. Bits are taken on serial clock rising edges, and the slave's own output changes only on falling edges.

Top module: `smi_slave`

## Requirements
- R1: During and right after reset, `mdio_oe`, `reg_we` and `reg_re` are all low.
- R2: A write frame whose opcode bits are 0 then 1 and whose device bits match `strap_addr` gives exactly one `reg_we` pulse, and it comes after the last data bit is sampled. With it, `reg_addr` carries the register bits (first bit is the MSB) and `reg_wdata` carries the last eight data bits. The first eight data bits have no effect.
- R3: A matching read frame (opcode bits 1 then 0) gives exactly one `reg_re` pulse, with `reg_addr` valid, once the last register bit is sampled and before any turnaround bit.
- R4: In a matching read, the host samples 0 in the second turnaround bit. It then samples sixteen data bits MSB first: eight zeros, then the `reg_rdata` value captured with `reg_re`.
- R5: `mdio_oe` is high only from the second turnaround bit through the last data bit of a matching read. It drops at the next falling serial clock edge and is never high during a write frame.
- R6: A zero that arrives before 32 consecutive ones have been sampled cancels the frame: no strobe and no drive.
- R7: A frame whose device bits differ from `strap_addr` causes no strobe and no drive.
- R8: Opcode bits 0,0 or 1,1 cause no strobe and no drive.
- R9: If a zero follows the opening zero of the start pattern where a one is expected, the frame is cancelled: no strobe and no drive.
- R10: A preamble longer than 32 ones is accepted the same as one of exactly 32.
- R11: `reg_we` and `reg_re` each last one system clock and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 2 | Device number this slave answers to |
| mdc | input | 1 | Serial clock from the host |
| mdio_i | input | 1 | Level seen on the shared data line |
| mdio_o | output | 1 | Value the slave drives onto the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | Register bus write strobe, one clock |
| reg_re | output | 1 | Register bus read strobe, one clock |
| reg_rdata | input | 8 | Register bus read data, valid while `reg_re` is high |

## Verification
Random read and write frames are sent with random register numbers and data, random preamble lengths from 32 to 40 ones, and device numbers that match or miss the strap. These tell decoding and strobe timing apart from address filtering. Directed frames send a 31-one preamble, a broken start pattern, the two illegal opcodes, an exact 32-one preamble and a longer one. Each shows whether the slave cancels the frame or accepts it. Every frame also records the drive-enable level at each host sample, so an early, late or spurious drive on the shared line is caught. The strap is changed once in mid-run to confirm the match follows the input.

// File: rtl/smi_pkg.sv
// Shared types for the serial management slave.
// Assumes: frames are decoded one bit per serial clock rising edge.
package smi_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SFD,
        ST_OP,
        ST_DEV,
        ST_REG,
        ST_TA,
        ST_DATA
    } smi_state_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/smi_edge_sync.sv
// Brings the serial clock and data line into the system clock domain and
// flags serial clock rising and falling edges as one-cycle pulses.
// Assumes: the serial clock runs far slower than clk (at least 8 clk per
// half period), and the data line is stable around each rising edge.
module smi_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_i,
    output logic rise,
    output logic fall,
    output logic bit_val
);
    logic [SYNC_STAGES:0]   mdc_q;
    logic [SYNC_STAGES-1:0] dio_q;

    // Synchroniser chains; the serial clock idles high, so reset to ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q <= '1;
            dio_q <= '1;
        end else begin
            mdc_q <= {mdc_q[SYNC_STAGES-1:0], mdc};
            dio_q <= {dio_q[SYNC_STAGES-2:0], mdio_i};
        end
    end

    assign rise    = mdc_q[SYNC_STAGES-1] & ~mdc_q[SYNC_STAGES];
    assign fall    = ~mdc_q[SYNC_STAGES-1] & mdc_q[SYNC_STAGES];
    assign bit_val = dio_q[SYNC_STAGES-1];
endmodule

// File: rtl/smi_frame_fsm.sv
// Frame decoder: hunts for the preamble, checks the start pattern, opcode
// and device number, collects the register number and data, and issues
// one-clock read and write strobes on the register bus.
// Assumes: rise/bit_val come from smi_edge_sync; any failed check returns
// to preamble hunting with the preamble count cleared.
module smi_frame_fsm
    import smi_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DEV_W   = 2,
    parameter int AW      = 8,
    parameter int DW      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             bit_val,
    input  logic [DEV_W-1:0] strap,
    output logic [AW-1:0]    reg_addr,
    output logic [DW-1:0]    reg_wdata,
    output logic             reg_we,
    output logic             reg_re
);
    localparam int FMAX = (2 * DW > AW) ? 2 * DW : AW;
    localparam int CW   = $clog2(FMAX);
    localparam int PW   = $clog2(PRE_LEN + 1);

    smi_state_e    state;
    logic [PW-1:0] pre_cnt;
    logic [CW-1:0] fld_cnt;
    logic [FMAX-1:0] sh;
    logic          is_read;
    logic          fld_last;
    logic [FMAX-1:0] sh_next;

    // Marks the final bit of the field the decoder is in
    always_comb begin
        case (state)
            ST_OP, ST_TA: fld_last = (fld_cnt == CW'(1));
            ST_DEV:       fld_last = (fld_cnt == CW'(DEV_W - 1));
            ST_REG:       fld_last = (fld_cnt == CW'(AW - 1));
            ST_DATA:      fld_last = (fld_cnt == CW'(2 * DW - 1));
            default:      fld_last = 1'b0;
        endcase
    end

    assign sh_next = {sh[FMAX-2:0], bit_val};

    // Frame sequencing, field capture and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            pre_cnt   <= '0;
            fld_cnt   <= '0;
            sh        <= '0;
            is_read   <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (rise) begin
                sh <= sh_next;
                if (state != ST_HUNT && state != ST_SFD)
                    fld_cnt <= fld_last ? '0 : fld_cnt + 1'b1;
                case (state)
                    ST_HUNT: begin
                        if (bit_val) begin
                            if (pre_cnt != PW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
                        end else begin
                            if (pre_cnt == PW'(PRE_LEN)) state <= ST_SFD;
                            pre_cnt <= '0;
                        end
                        fld_cnt <= '0;
                    end
                    ST_SFD:  state <= bit_val ? ST_OP : ST_HUNT;
                    ST_OP: if (fld_last) begin
                        if (sh_next[1:0] == OP_READ) begin
                            is_read <= 1'b1;
                            state   <= ST_DEV;
                        end else if (sh_next[1:0] == OP_WRITE) begin
                            is_read <= 1'b0;
                            state   <= ST_DEV;
                        end else begin
                            state   <= ST_HUNT;
                        end
                    end
                    ST_DEV: if (fld_last)
                        state <= (sh_next[DEV_W-1:0] == strap) ? ST_REG : ST_HUNT;
                    ST_REG: if (fld_last) begin
                        reg_addr <= sh_next[AW-1:0];
                        reg_re   <= is_read;
                        state    <= ST_TA;
                    end
                    ST_TA: if (fld_last) state <= ST_DATA;
                    ST_DATA: if (fld_last) begin
                        if (!is_read) begin
                            reg_wdata <= sh_next[DW-1:0];
                            reg_we    <= 1'b1;
                        end
                        state <= ST_HUNT;
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));
    assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_re_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);
    assert_we_after_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(rise));
    assert_re_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> $past(rise));
endmodule

// File: rtl/smi_tx.sv
// Read-return shifter: after a read strobe, counts serial clock falling
// edges, leaves the first turnaround bit undriven, drives 0 in the second,
// shifts out the zero-padded data word MSB first and then releases the line.
// Assumes: reg_rdata is valid in the cycle the load pulse is high, and the
// first falling edge after load starts the first turnaround bit.
module smi_tx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic          load,
    input  logic [DW-1:0] rdata,
    output logic          mdio_o,
    output logic          mdio_oe
);
    localparam int FW        = $clog2(2 * DW + 3);
    localparam int FIRST_D   = 2;
    localparam int LAST_D    = 2 * DW + 1;
    localparam int RELEASE_N = 2 * DW + 2;

    logic [FW-1:0]   fcnt;
    logic [2*DW-1:0] sh;
    logic            armed;

    // Falling-edge sequencing of the returned turnaround and data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt    <= '0;
            sh      <= '0;
            armed   <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (load) begin
            fcnt    <= '0;
            sh      <= {{DW{1'b0}}, rdata};
            armed   <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (fall && armed) begin
            fcnt <= fcnt + 1'b1;
            if (fcnt == FW'(1)) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
            end else if (fcnt >= FW'(FIRST_D) && fcnt <= FW'(LAST_D)) begin
                mdio_o <= sh[2*DW-1];
                sh     <= {sh[2*DW-2:0], 1'b0};
            end else if (fcnt == FW'(RELEASE_N)) begin
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
                armed   <= 1'b0;
            end
        end
    end

    assert_oe_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe != $past(mdio_oe)) |-> $past(fall));
    assert_first_drive_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> (mdio_o == 1'b0));
endmodule

// File: rtl/smi_slave.sv
// Serial management slave top: synchroniser, frame decoder and read-return
// shifter joined to a parallel register bus on the system clock.
// Assumes: one host drives mdc and the data line; the pad merges mdio_o,
// mdio_oe and the host drive into mdio_i.
module smi_slave #(
    parameter int PRE_LEN     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DEV_W       = 2,
    parameter int AW          = 8,
    parameter int DW          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] strap_addr,
    input  logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [AW-1:0]    reg_addr,
    output logic [DW-1:0]    reg_wdata,
    output logic             reg_we,
    output logic             reg_re,
    input  logic [DW-1:0]    reg_rdata
);
    logic rise, fall, bit_val;

    smi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_i(mdio_i),
        .rise(rise), .fall(fall), .bit_val(bit_val)
    );

    smi_frame_fsm #(.PRE_LEN(PRE_LEN), .DEV_W(DEV_W), .AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .bit_val(bit_val),
        .strap(strap_addr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re)
    );

    smi_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .fall(fall), .load(reg_re),
        .rdata(reg_rdata), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    assert_no_drive_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !mdio_oe);
    assert_no_drive_at_read_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> !mdio_oe);
endmodule

// File: tb/sim_smi_slave.sv
module sim_smi_slave;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n;
    logic [1:0] strap;
    logic       mdc;
    logic       host_en, host_val;
    logic       mdio_o, mdio_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we, reg_re;
    logic       line;

    int nvec = 0;
    int nerr = 0;
    int we_tot = 0, re_tot = 0, overlap = 0, long_we = 0, long_re = 0;
    logic [7:0] we_addr, we_data, re_addr;
    logic prev_we = 1'b0, prev_re = 1'b0;

    assign line = mdio_oe ? mdio_o : (host_en ? host_val : 1'b1);

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hC3;
    endfunction

    assign reg_rdata = exp_rd(reg_addr);

    smi_slave u0 (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap), .mdc(mdc), .mdio_i(line),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata)
    );

    // Bus monitor: strobe totals, captured values and pulse shape (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin we_tot++; we_addr = reg_addr; we_data = reg_wdata; end
            if (reg_re) begin re_tot++; re_addr = reg_addr; end
            if (reg_we && reg_re) overlap++;
            if (reg_we && prev_we) long_we++;
            if (reg_re && prev_re) long_re++;
            prev_we = reg_we;
            prev_re = reg_re;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic en, input logic v, output logic smp, output logic oe_s);
        @(negedge clk);
        mdc = 1'b0; host_en = en; host_val = v;
        repeat (8) @(negedge clk);
        smp = line; oe_s = mdio_oe;
        mdc = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_frame(input string req, input int npre, input logic [1:0] sfd,
                            input logic [1:0] op, input logic [1:0] dev,
                            input logic [7:0] addr, input logic [15:0] data);
        logic s, o, any_oe, ta2, oe_after;
        logic [15:0] rx;
        logic [17:0] oev;
        int we0, re0;
        bit valid, hrel;
        we0 = we_tot; re0 = re_tot;
        any_oe = 1'b0;
        hrel = (op == 2'b10);
        send_bit(1'b1, 1'b0, s, o); any_oe |= o;
        for (int i = 0; i < npre; i++) begin send_bit(1'b1, 1'b1, s, o); any_oe |= o; end
        for (int i = 1; i >= 0; i--) begin send_bit(1'b1, sfd[i], s, o); any_oe |= o; end
        for (int i = 1; i >= 0; i--) begin send_bit(1'b1, op[i], s, o); any_oe |= o; end
        for (int i = 1; i >= 0; i--) begin send_bit(1'b1, dev[i], s, o); any_oe |= o; end
        for (int i = 7; i >= 0; i--) begin send_bit(1'b1, addr[i], s, o); any_oe |= o; end
        send_bit(!hrel, 1'b1, s, o); oev[0] = o;
        send_bit(!hrel, 1'b0, s, o); oev[1] = o; ta2 = s;
        for (int i = 15; i >= 0; i--) begin
            send_bit(!hrel, data[i], s, o); rx[i] = s; oev[17 - i] = o;
        end
        send_bit(1'b0, 1'b1, s, oe_after);
        repeat (4) @(negedge clk);
        valid = (npre >= 32) && (sfd == 2'b01) && (op == 2'b10 || op == 2'b01) && (dev == strap);
        chk({req, " write strobe count"}, we_tot - we0, (valid && op == 2'b01) ? 1 : 0);
        chk({req, " read strobe count"}, re_tot - re0, (valid && op == 2'b10) ? 1 : 0);
        chk({req, " no drive before turnaround"}, any_oe, 0);
        chk({req, " line released after frame"}, oe_after, 0);
        if (valid && op == 2'b01) begin
            chk("R2 write address", we_addr, addr);
            chk("R2 write data low byte", we_data, data[7:0]);
        end
        if (valid && op == 2'b10) begin
            chk("R3 read address", re_addr, addr);
            chk("R4 turnaround zero", ta2, 1'b0);
            chk("R4 read data", rx, {8'h00, exp_rd(addr)});
            chk("R5 drive window", oev, 18'h3FFFE);
        end else begin
            chk({req, " no drive in frame"}, oev, 18'h0);
        end
    endtask

    initial begin
        logic [1:0] op, dv;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mdc = 1'b1; host_en = 1'b0; host_val = 1'b1; strap = 2'b10;
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", mdio_oe, 0);
        chk("R1 strobes in reset", {reg_we, reg_re}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 oe after reset", mdio_oe, 0);
        chk("R1 strobes after reset", {reg_we, reg_re}, 0);

        do_frame("R2", 32, 2'b01, 2'b01, 2'b10, 8'hA5, 16'hFF3C);
        do_frame("R3", 32, 2'b01, 2'b10, 2'b10, 8'h00, 16'h0);
        do_frame("R3", 32, 2'b01, 2'b10, 2'b10, 8'hFF, 16'h0);
        do_frame("R6", 31, 2'b01, 2'b01, 2'b10, 8'h11, 16'h0077);
        do_frame("R6", 31, 2'b01, 2'b10, 2'b10, 8'h11, 16'h0);
        do_frame("R9", 32, 2'b00, 2'b01, 2'b10, 8'h22, 16'h0055);
        do_frame("R8", 32, 2'b01, 2'b00, 2'b10, 8'h33, 16'h00AA);
        do_frame("R8", 32, 2'b01, 2'b11, 2'b10, 8'h44, 16'h00AA);
        do_frame("R7", 32, 2'b01, 2'b01, 2'b01, 8'h55, 16'h0012);
        do_frame("R7", 32, 2'b01, 2'b10, 2'b11, 8'h55, 16'h0);
        do_frame("R10", 40, 2'b01, 2'b01, 2'b10, 8'h66, 16'h1234);
        do_frame("R10", 45, 2'b01, 2'b10, 2'b10, 8'h77, 16'h0);

        for (int k = 0; k < 40; k++) begin
            if (k == 20) strap = 2'b01;
            op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            dv = ($urandom % 4 == 0) ? 2'($urandom) : strap;
            do_frame(op == 2'b01 ? "R2" : "R3", 32 + int'($urandom % 9), 2'b01, op, dv,
                     8'($urandom), 16'($urandom));
        end

        chk("R11 strobes overlap", overlap, 0);
        chk("R11 write strobe width", long_we, 0);
        chk("R11 read strobe width", long_re, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule